// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit linear address into a 40-bit physical address. It walks a four-level radix-512 translation tree held in memory. Each table holds 512 eight-byte entries. The walk begins at a table whose 4 KB-aligned physical base comes from the root base input (bits 39:12). Every entry that is fetched supplies the base of the next table, at bits 39:12.

At the third level, a directory entry with its size flag set ends the walk early and maps a 2 MB frame. Otherwise a fourth read maps a 4 KB frame. An entry that is not present aborts the walk with a fault that names the level where it stopped. An address whose upper bits are not a sign extension of bit 47 faults at once, with no memory traffic.

Translations are issued on a valid/ready request port. Results come back as a single-cycle response pulse. Table entries are fetched over a simple read port: the walker holds a request and its address until the memory acknowledges with the data in the same cycle. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `req_ready` is 1, `rd_req` is 0 and `rsp_valid` is 0.
- R2: The first read of a walk is at the root base bits 39:12, followed by linear bits 47:39 as a 9-bit index, followed by three zero bits. Every read address therefore has bits 2:0 equal to zero.
- R3: The reads go in the order root entry, pointer entry, directory entry, page entry. Each read uses the previous entry's bits 39:12 as the table base. The indexes come from linear bits 38:30, 29:21 and 20:12 respectively.
- R4: If the directory entry has bit 7 clear, a fourth read is issued. The response then has fault 0, large 0 and a physical address equal to that entry's bits 39:12 followed by linear bits 11:0.
- R5: If the directory entry (the third read) is present and has bit 7 set, no fourth read is issued. The response has fault 0, large 1 and a physical address equal to that entry's bits 39:21 followed by linear bits 20:0.
- R6: An entry with bit 0 clear ends the walk with fault 1 and no further reads. `rsp_level` is 4, 3, 2 or 1 when the failing entry is the root, pointer, directory or page entry respectively.
- R7: An address whose bits 63:48 are not all equal to bit 47 is answered with fault 1 and `rsp_level` 0. No read is issued, and `rsp_valid` rises in the cycle after the request is accepted.
- R8: `req_ready` is 0 from acceptance until the response. `rsp_valid` is high for exactly one cycle, in the cycle after the last read is acknowledged.
- R9: `rd_req` and `rd_addr` stay unchanged from the cycle the request is raised until the cycle `rd_ack` is seen, however many wait cycles the memory inserts.
- R10: Bit 7 has no effect in root, pointer and page entries: a walk whose other entries carry bit 7 still makes all four reads and returns a 4 KB mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 64 | Top table base; bits 39:12 used |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 64 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 40 | Translated physical address |
| rsp_fault | output | 1 | Walk failed |
| rsp_level | output | 3 | Fault level: 0 non-canonical, 4..1 table level |
| rsp_large | output | 1 | Result maps a 2 MB frame |
| rd_req | output | 1 | Entry read request |
| rd_addr | output | 40 | Entry physical address |
| rd_ack | input | 1 | Read acknowledge, data valid this cycle |
| rd_data | input | 64 | Entry contents |

## Verification
The translation is tried with several input patterns:
- A plain 4 KB walk with junk in upper entry bits.
- A 2 MB mapping reached through a negative canonical address.
- A missing entry at each of the four levels.
- Both directions of non-canonical address.
- A walk that sets bit 7 in every entry except the directory.

For each walk, the count of reads and every read address are compared with a chain the bench computes. This separates early termination from a full walk, and shows whether the index slice and the base slice are correct at each level. The memory adds zero to two wait cycles per read, which exposes any address that is not held steady across the handshake.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W    = 40,
  parameter int VA_BITS = 48,
  parameter int IDX_W   = 9,
  parameter int PG_W    = 12,
  parameter int PS_BIT  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [63:0]     root_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic [2:0]      rsp_level,
  output logic            rsp_large,
  output logic            rd_req,
  output logic [PA_W-1:0] rd_addr,
  input  logic            rd_ack,
  input  logic [63:0]     rd_data
);
  localparam int LG_W   = PG_W + IDX_W;
  localparam int ENT_SH = PG_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} st_t;

  st_t                 st;
  logic [1:0]          lvl;
  logic [VA_BITS-1:0]  va;
  logic [PA_W-1:PG_W]  base;
  logic [IDX_W-1:0]    idx;
  logic [63:VA_BITS-1] hi;
  logic                canon;
  logic                unused_bits;

  assign hi    = req_vaddr[63:VA_BITS-1];
  assign canon = (&hi) | ~(|hi);
  assign idx   = va[PG_W + IDX_W*int'(lvl) +: IDX_W];

  assign req_ready = (st == S_IDLE);
  assign rd_req    = (st == S_WALK);
  assign rsp_valid = (st == S_DONE);
  assign rd_addr   = {base, idx, {ENT_SH{1'b0}}};

  assign unused_bits = ^{rd_data[63:PA_W], rd_data[PG_W-1:1],
                         root_base[63:PA_W], root_base[PG_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lvl       <= 2'd3;
      va        <= '0;
      base      <= '0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_level <= 3'd0;
      rsp_large <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va        <= req_vaddr[VA_BITS-1:0];
          base      <= root_base[PA_W-1:PG_W];
          lvl       <= 2'd3;
          rsp_paddr <= '0;
          rsp_level <= 3'd0;
          rsp_large <= 1'b0;
          rsp_fault <= ~canon;
          st        <= canon ? S_WALK : S_DONE;
        end
        S_WALK: if (rd_ack) begin
          if (!rd_data[0]) begin
            rsp_fault <= 1'b1;
            rsp_level <= {1'b0, lvl} + 3'd1;
            st        <= S_DONE;
          end else if (lvl == 2'd1 && rd_data[PS_BIT]) begin
            rsp_paddr <= {rd_data[PA_W-1:LG_W], va[LG_W-1:0]};
            rsp_large <= 1'b1;
            st        <= S_DONE;
          end else if (lvl == 2'd0) begin
            rsp_paddr <= {rd_data[PA_W-1:PG_W], va[PG_W-1:0]};
            st        <= S_DONE;
          end else begin
            base <= rd_data[PA_W-1:PG_W];
            lvl  <= lvl - 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[ENT_SH-1:0] == '0);

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  a_r6_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && !rd_data[0]) |=> (rsp_valid && rsp_fault && !rd_req));

  a_r7_noncanon_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !((&req_vaddr[63:VA_BITS-1]) || !(|req_vaddr[63:VA_BITS-1])))
    |=> (rsp_valid && rsp_fault && rsp_level == 3'd0));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r8_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (rd_req || rsp_valid)));

  a_r5_large_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_large) |-> !rsp_fault);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  typedef struct packed {
    logic [63:0] va;
    logic [63:0] e0, e1, e2, e3;
    logic [39:0] pa;
    logic        flt;
    logic [2:0]  lvl;
    logic        lg;
    logic [2:0]  nr;
  } vec_t;

  localparam logic [63:0] ROOT = 64'h0000_0012_3456_7000;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_1234_5678_9ABC, 64'h0000_0011_1000_0003, 64'h0000_0022_2000_0001,
      64'h0000_0033_3000_0001, 64'h8000_00AA_BBCC_D001, 40'hAA_BBCC_DABC, 1'b0, 3'd0, 1'b0, 3'd4},
    '{64'hFFFF_8000_0060_1234, 64'h0000_0011_1000_0001, 64'h0000_0022_2000_0001,
      64'h0000_0044_4460_0081, 64'h0, 40'h44_4460_1234, 1'b0, 3'd0, 1'b1, 3'd3},
    '{64'h0000_0000_0000_0000, 64'h0000_0011_1000_0000, 64'h0, 64'h0, 64'h0,
      40'h0, 1'b1, 3'd4, 1'b0, 3'd1},
    '{64'h0000_7FFF_FFFF_FFFF, 64'h0000_0011_1000_0001, 64'h0000_0055_5000_0080,
      64'h0, 64'h0, 40'h0, 1'b1, 3'd3, 1'b0, 3'd2},
    '{64'hFFFF_8000_0000_0000, 64'h0000_0011_1000_0001, 64'h0000_0022_2000_0001,
      64'h0000_0033_3000_0080, 64'h0, 40'h0, 1'b1, 3'd2, 1'b0, 3'd3},
    '{64'h0000_0000_DEAD_B000, 64'h0000_0011_1000_0001, 64'h0000_0022_2000_0001,
      64'h0000_0033_3000_0001, 64'h0000_0044_4000_0000, 40'h0, 1'b1, 3'd1, 1'b0, 3'd4},
    '{64'h0000_8000_0000_0000, 64'h0, 64'h0, 64'h0, 64'h0, 40'h0, 1'b1, 3'd0, 1'b0, 3'd0},
    '{64'hFFFF_0000_0000_1000, 64'h0, 64'h0, 64'h0, 64'h0, 40'h0, 1'b1, 3'd0, 1'b0, 3'd0},
    '{64'hFFFF_FFFF_FFFF_F000, 64'h0000_0066_6000_0081, 64'h0000_0077_7000_0081,
      64'h0000_0088_8000_0001, 64'h0000_0099_9000_0081, 40'h99_9000_0000, 1'b0, 3'd0, 1'b0, 3'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rd_ack = 1'b0;
  logic [63:0] req_vaddr = '0, rd_data = '0;
  logic req_ready, rsp_valid, rsp_fault, rsp_large, rd_req;
  logic [39:0] rsp_paddr, rd_addr;
  logic [2:0] rsp_level;

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_base(ROOT),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_large(rsp_large),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  int checks = 0, failures = 0;
  logic [63:0] ents [4];
  logic [39:0] addrs [8];
  int nrd = 0, wait_n = 0, wcnt = 0, stab_bad = 0;
  logic [39:0] held;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.flt && v.lvl == 3'd0) return "R7";
    if (v.flt) return "R6";
    if (v.lg) return "R5";
    if (v.e0[7]) return "R10";
    return "R4";
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req) begin
        if (wcnt == 0) held = rd_addr;
        else if (rd_addr != held) stab_bad++;
        if (wcnt < wait_n) wcnt++;
        else begin
          if (nrd < 8) addrs[nrd] = rd_addr;
          rd_data = ents[(nrd > 3) ? 3 : nrd];
          rd_ack = 1'b1;
          nrd++;
          wcnt = 0;
        end
      end
    end
  end

  task automatic do_walk(input vec_t v, input int n);
    int cyc;
    bit busy_bad;
    logic [27:0] b;
    string t;
    t = tag_of(v);
    ents[0] = v.e0; ents[1] = v.e1; ents[2] = v.e2; ents[3] = v.e3;
    nrd = 0; wait_n = n % 3; stab_bad = 0; busy_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 100) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    chk(rsp_valid, "R8 response seen", 64'(rsp_valid), 64'd1);
    chk(!busy_bad, "R8 ready low during walk", 64'(busy_bad), 64'd0);
    chk(rsp_fault == v.flt, {t, " fault"}, 64'(rsp_fault), 64'(v.flt));
    if (v.flt) chk(rsp_level == v.lvl, {t, " level"}, 64'(rsp_level), 64'(v.lvl));
    else begin
      chk(rsp_paddr == v.pa, {t, " paddr"}, 64'(rsp_paddr), 64'(v.pa));
      chk(rsp_large == v.lg, {t, " large"}, 64'(rsp_large), 64'(v.lg));
    end
    chk(nrd == int'(v.nr), {t, " read count"}, 64'(nrd), 64'(v.nr));
    if (v.nr == 3'd0) chk(cyc == 1, "R7 latency", 64'(cyc), 64'd1);
    chk(stab_bad == 0, "R9 address held", 64'(stab_bad), 64'd0);
    b = ROOT[39:12];
    for (int k = 0; k < int'(v.nr) && k < nrd; k++) begin
      logic [39:0] ea;
      ea = {b, v.va[12 + 9*(3-k) +: 9], 3'b000};
      chk(addrs[k] == ea, (k == 0) ? "R2 first address" : "R3 walk address",
          64'(addrs[k]), 64'(ea));
      b = ents[k][39:12];
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 single pulse", 64'({rsp_valid, req_ready}), 64'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rd_req && !rsp_valid, "R1 in reset",
        64'({req_ready, rd_req, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rd_req && !rsp_valid, "R1 after reset",
        64'({req_ready, rd_req, rsp_valid}), 64'b100);
    for (int i = 0; i < NV; i++) do_walk(VEC[i], i);
    do_walk(VEC[0], 2);
    do_walk(VEC[1], 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule